// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a clocked request interface and an external asynchronous static RAM with a 16-bit data bus and two byte lanes. A client presents an address, a write word, a two-bit byte mask and a read or write command under a valid/ready handshake. The controller then drives the memory pins: a low-active and a high-active chip select, a low-active output enable, a low-active write enable and two low-active byte enables. It returns the read word together with a one-cycle completion pulse.

Each access phase is timed by counting clock cycles. The count is the rounded-up quotient of a nanosecond minimum over the clock period, and it is never less than one cycle. The clock period and all minimums are parameters. With the default values (10 ns clock, 55 ns cycle limits), a read holds the memory selected for 6 cycles. A write holds the write enable low for 6 cycles, and the controller's data drivers switch on in the second of those cycles. The bidirectional data bus appears as separate in, out and drive-enable signals.

The state machine has four states. ST_IDLE waits for a request. ST_READ drives a read access. ST_WRITE drives a write access. ST_TURN is a one-cycle bus turnaround. The transitions are:
- ST_IDLE to ST_READ when a read with a non-empty mask is accepted.
- ST_IDLE to ST_WRITE when a write with a non-empty mask is accepted and the previous access was not a read.
- ST_IDLE to ST_TURN when such a write follows a read.
- ST_TURN to ST_WRITE after one cycle.
- ST_READ to ST_IDLE, and ST_WRITE to ST_IDLE, on the last cycle of the phase.
- ST_IDLE to ST_IDLE when a request with an all-zero mask is accepted. Such a request is completed without any bus activity.

Top module: `sram_ctl`

## Requirements
- R1: During reset and right after it, the pins are inactive: mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1, mem_be_n=2'b11 and mem_dq_oe=0. In the same period req_ready=1, rsp_done=0 and rsp_rdata=0. An asserted reset in the middle of an access returns the pins to this state at once.
- R2: A read keeps the device selected (mem_cs_n=0, mem_cs=1) with mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC cycles (6 by default). rsp_done rises one cycle after the last of them, which is 7 cycles after acceptance. rsp_rdata carries the bus word sampled in the last read cycle.
- R3: A write holds mem_we_n=0 for exactly WR_CYC cycles (6 by default). Both selects and the masked byte enables are active in those cycles, and mem_oe_n stays 1 throughout. rsp_done follows 7 cycles after acceptance.
- R4: mem_dq_oe is 0 in the first cycle with mem_we_n low, 1 in every later cycle with mem_we_n low, and 0 whenever mem_we_n is high.
- R5: Mask bit 1 selects the upper byte (dq[15:8], mem_be_n[1]). Mask bit 0 selects the lower byte (dq[7:0], mem_be_n[0]). mem_be_n is the inverse of the mask during an access. Only the enabled lanes of memory are written.
- R6: A request with mask 2'b00 produces no cycle with mem_cs_n low. It completes with rsp_done one cycle after acceptance.
- R7: A write accepted right after a read is completed passes through one turnaround cycle. Its latency is 8 cycles, and the gap with the device deselected between the two accesses is 2 cycles instead of 1.
- R8: req_ready is low from acceptance until the cycle of rsp_done. rsp_done is a single-cycle pulse.
- R9: rsp_rdata changes only when a read completes. Writes and empty requests leave it unchanged.
- R10: mem_addr equals the accepted address and stays stable for every cycle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| req_mask | input | DW/8 | Byte lane mask, bit 1 upper byte, bit 0 lower byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Last read word, held |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_dq_i | input | DW | Data bus as seen from the memory |
| mem_dq_o | output | DW | Data driven by the controller |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
The assertions assume that the client raises req_valid only with stable request fields. They also assume that reset is the only event that can cut an access short, so each phase runs to its full count. The bench drives every request field at a falling edge, keeps it until the accepting rising edge, and only then lowers req_valid. It never requests while req_ready is low. The memory model returns data only while the output enable and a byte enable are active, and it returns zero in disabled lanes. As a result, each read result depends on the lane mapping alone.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_TURN  = 2'd3
    } sram_state_t;

    // rounded-up cycle count for a nanosecond minimum, never below one
    function automatic int ns_to_cyc(input int ns, input int per_ns);
        int c;
        c = (ns + per_ns - 1) / per_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_tmr.sv
module sram_phase_tmr #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] wdata_in,
    input  logic          cap,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata
);

    localparam int NB = DW / 8;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] rd_lane_q;
        logic [7:0] wr_lane_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_lane_q <= '0;
            end else if (cap) begin
                rd_lane_q <= dq_in[g*8 +: 8];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wr_lane_q <= '0;
            end else if (load) begin
                wr_lane_q <= wdata_in[g*8 +: 8];
            end
        end

        assign rdata[g*8 +: 8]  = rd_lane_q;
        assign dq_out[g*8 +: 8] = wr_lane_q;
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW            = 8,
    parameter int DW            = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RD_CYCLE    = 55,
    parameter int T_ADDR_DATA   = 55,
    parameter int T_SEL_DATA    = 55,
    parameter int T_OE_DATA     = 25,
    parameter int T_BE_DATA     = 55,
    parameter int T_WR_CYCLE    = 55,
    parameter int T_WE_PULSE    = 40,
    parameter int T_SEL_WEND    = 40,
    parameter int T_ADDR_WEND   = 40,
    parameter int T_BE_WEND     = 40,
    parameter int T_DATA_WEND   = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [DW/8-1:0] req_mask,
    output logic            rsp_done,
    output logic [DW-1:0]   rsp_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_cs_n,
    output logic            mem_cs,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic [DW/8-1:0] mem_be_n,
    input  logic [DW-1:0]   mem_dq_i,
    output logic [DW-1:0]   mem_dq_o,
    output logic            mem_dq_oe
);

    localparam int NB = DW / 8;
    localparam int RD_CYC = imax(
        imax(ns_to_cyc(T_RD_CYCLE, CLK_PERIOD_NS), ns_to_cyc(T_ADDR_DATA, CLK_PERIOD_NS)),
        imax(ns_to_cyc(T_SEL_DATA, CLK_PERIOD_NS),
             imax(ns_to_cyc(T_OE_DATA, CLK_PERIOD_NS), ns_to_cyc(T_BE_DATA, CLK_PERIOD_NS))));
    // data drivers start one cycle late, so data setup needs one extra cycle
    localparam int WR_CYC = imax(
        imax(ns_to_cyc(T_WR_CYCLE, CLK_PERIOD_NS), ns_to_cyc(T_WE_PULSE, CLK_PERIOD_NS)),
        imax(imax(ns_to_cyc(T_SEL_WEND, CLK_PERIOD_NS), ns_to_cyc(T_BE_WEND, CLK_PERIOD_NS)),
             imax(ns_to_cyc(T_ADDR_WEND, CLK_PERIOD_NS), ns_to_cyc(T_DATA_WEND, CLK_PERIOD_NS) + 1)));
    localparam int CW = $clog2(imax(RD_CYC, WR_CYC) + 1);

    sram_state_t     st_q, st_d;
    logic [CW-1:0]   cnt;
    logic            tmr_clr;
    logic            accept;
    logic            empty_req;
    logic            phase_last;
    logic            cap;
    logic            wr_load;
    logic            last_rd_q;
    logic            done_q;
    logic [AW-1:0]   addr_q;
    logic [NB-1:0]   mask_q;

    assign req_ready  = (st_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign empty_req  = accept && (req_mask == '0);
    assign phase_last = ((st_q == ST_READ)  && (cnt == CW'(RD_CYC - 1))) ||
                        ((st_q == ST_WRITE) && (cnt == CW'(WR_CYC - 1)));
    assign cap        = (st_q == ST_READ) && phase_last;
    assign wr_load    = accept && !empty_req && req_write;
    assign tmr_clr    = (st_q != st_d);

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept && !empty_req) begin
                    if (!req_write)     st_d = ST_READ;
                    else if (last_rd_q) st_d = ST_TURN;
                    else                st_d = ST_WRITE;
                end
            end
            ST_READ:  if (phase_last) st_d = ST_IDLE;
            ST_WRITE: if (phase_last) st_d = ST_IDLE;
            ST_TURN:  st_d = ST_WRITE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // request capture and completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            mask_q    <= '0;
            last_rd_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= phase_last || empty_req;
            if (accept && !empty_req) begin
                addr_q    <= req_addr;
                mask_q    <= req_mask;
                last_rd_q <= !req_write;
            end
        end
    end

    // pin decode from state
    always_comb begin
        mem_cs_n  = 1'b1;
        mem_cs    = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_be_n  = '1;
        mem_dq_oe = 1'b0;
        unique case (st_q)
            ST_READ: begin
                mem_cs_n = 1'b0;
                mem_cs   = 1'b1;
                mem_oe_n = 1'b0;
                mem_be_n = ~mask_q;
            end
            ST_WRITE: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_we_n  = 1'b0;
                mem_be_n  = ~mask_q;
                mem_dq_oe = (cnt != '0);
            end
            ST_IDLE, ST_TURN: begin
            end
            default: begin
            end
        endcase
    end

    assign mem_addr = addr_q;
    assign rsp_done = done_q;

    sram_phase_tmr #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (cnt)
    );

    sram_dq_path #(.DW(DW)) u_dq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_load),
        .wdata_in (req_wdata),
        .cap      (cap),
        .dq_in    (mem_dq_i),
        .dq_out   (mem_dq_o),
        .rdata    (rsp_rdata)
    );

    AST_RD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_cs && mem_we_n)); // R2
    AST_WR_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R3
    AST_DQ_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n))); // R4
    AST_NO_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> (mem_be_n != '1)); // R6
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2))); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp_rdata) |-> rsp_done); // R9
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R10

endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [7:0]  mem_addr;
    logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_i, mem_dq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sram_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe)
    );

    // memory model and reference copy
    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];

    function automatic logic [15:0] pre(input int i);
        return 16'(i * 16'h0101) ^ 16'h5a3c;
    endfunction

    always_comb begin
        mem_dq_i = '0;
        if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) begin
            for (int b = 0; b < 2; b++)
                if (!mem_be_n[b]) mem_dq_i[b*8 +: 8] = mem[mem_addr][b*8 +: 8];
        end
    end

    // bus monitor, samples at falling edges
    int wlow = 0, last_wlow = 0, rlow = 0, last_rlow = 0;
    int gap = 0, last_gap = 0, act_total = 0;
    int dq_early = 0, dq_stray = 0, oe_clash = 0, addr_bad = 0;
    logic was_act = 1'b0, wseen = 1'b0;
    logic [7:0]  prev_addr = '0, wadr = '0;
    logic [15:0] wbuf = '0;
    logic [1:0]  wbe = '1;

    always @(negedge clk) begin
        if (!mem_we_n) begin
            if (wlow == 0 && mem_dq_oe) dq_early++;
            if (wlow != 0 && !mem_dq_oe) dq_early++;
            if (!mem_oe_n) oe_clash++;
            if (mem_dq_oe) begin
                wbuf = mem_dq_o; wadr = mem_addr; wbe = mem_be_n; wseen = 1'b1;
            end
            wlow++;
        end else begin
            if (mem_dq_oe) dq_stray++;
            if (wlow != 0) begin
                last_wlow = wlow;
                wlow = 0;
                if (wseen)
                    for (int b = 0; b < 2; b++)
                        if (!wbe[b]) mem[wadr][b*8 +: 8] = wbuf[b*8 +: 8];
                wseen = 1'b0;
            end
        end
        if (!mem_oe_n) rlow++;
        else if (rlow != 0) begin
            last_rlow = rlow;
            rlow = 0;
        end
        if (!mem_cs_n) begin
            act_total++;
            if (was_act && mem_addr != prev_addr) addr_bad++;
            if (!was_act) last_gap = gap;
            gap = 0;
        end else begin
            gap++;
        end
        was_act   = !mem_cs_n;
        prev_addr = mem_addr;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int lat;
    int rdy_bad;

    // issue one request and wait for its completion
    task automatic do_req(input logic wr, input logic [7:0] a, input logic [15:0] d,
                          input logic [1:0] m);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        rdy_bad = 0;
        do begin
            @(negedge clk);
            #1;
            lat++;
            if (!rsp_done && req_ready) rdy_bad++;
        end while (!rsp_done && lat < 40);
    endtask

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [15:0] d;
        logic [1:0]  m;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b1, 8'h10, 16'hA1B2, 2'b11, 4'd7},
        '{1'b0, 8'h10, 16'h0000, 2'b11, 4'd7},
        '{1'b1, 8'h11, 16'hC3D4, 2'b01, 4'd8},
        '{1'b0, 8'h11, 16'h0000, 2'b11, 4'd7},
        '{1'b1, 8'h12, 16'h1234, 2'b10, 4'd8},
        '{1'b1, 8'h12, 16'hFFFF, 2'b01, 4'd7},
        '{1'b0, 8'h12, 16'h0000, 2'b10, 4'd7},
        '{1'b0, 8'h12, 16'h0000, 2'b01, 4'd7},
        '{1'b0, 8'h13, 16'h0000, 2'b11, 4'd7},
        '{1'b1, 8'h13, 16'h0000, 2'b00, 4'd1},
        '{1'b1, 8'h13, 16'hBEEF, 2'b11, 4'd8},
        '{1'b0, 8'h13, 16'h0000, 2'b11, 4'd7}
    };

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] exp_rd;
        logic [15:0] held;
        int act_before;
        logic prev_rd;
        logic prev_empty;

        for (int i = 0; i < 256; i++) begin
            mem[i] = pre(i);
            ref_mem[i] = pre(i);
        end

        // reset state
        repeat (3) @(negedge clk);
        #1;
        chk({mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe} == 7'b1011110,
            "R1 pins in reset", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 7'b1011110);
        chk(req_ready && !rsp_done && rsp_rdata == 16'h0, "R1 ready/done/rdata in reset",
            {req_ready, rsp_done, rsp_rdata}, {2'b10, 16'h0});
        rst_n = 1'b1;
        @(negedge clk);
        #1;

        // table walk
        prev_rd    = 1'b0;
        prev_empty = 1'b0;
        for (int i = 0; i < 12; i++) begin
            held       = rsp_rdata;
            act_before = act_total;
            do_req(VEC[i].wr, VEC[i].a, VEC[i].d, VEC[i].m);
            chk(lat == int'(VEC[i].lat), "R2 R3 R6 R7 latency", lat, VEC[i].lat);
            chk(rdy_bad == 0, "R8 ready low while busy", rdy_bad, 0);
            if (VEC[i].m == 2'b00) begin
                chk(act_total == act_before, "R6 empty mask no bus cycle", act_total, act_before);
                chk(rsp_rdata == held, "R9 rdata kept on empty request", rsp_rdata, held);
            end else if (VEC[i].wr) begin
                for (int b = 0; b < 2; b++)
                    if (VEC[i].m[b]) ref_mem[VEC[i].a][b*8 +: 8] = VEC[i].d[b*8 +: 8];
                chk(last_wlow == 6, "R3 write enable width", last_wlow, 6);
                chk(mem[VEC[i].a] == ref_mem[VEC[i].a], "R5 lanes written", mem[VEC[i].a], ref_mem[VEC[i].a]);
                chk(rsp_rdata == held, "R9 rdata kept on write", rsp_rdata, held);
            end else begin
                exp_rd = '0;
                for (int b = 0; b < 2; b++)
                    if (VEC[i].m[b]) exp_rd[b*8 +: 8] = ref_mem[VEC[i].a][b*8 +: 8];
                chk(last_rlow == 6, "R2 output enable width", last_rlow, 6);
                chk(rsp_rdata == exp_rd, "R2 R5 read data", rsp_rdata, exp_rd);
            end
            if (i > 0 && VEC[i].m != 2'b00 && !prev_empty)
                chk(last_gap == ((prev_rd && VEC[i].wr) ? 2 : 1), "R7 deselected gap",
                    last_gap, (prev_rd && VEC[i].wr) ? 2 : 1);
            prev_empty = (VEC[i].m == 2'b00);
            if (VEC[i].m != 2'b00) prev_rd = !VEC[i].wr;
        end

        // done is a single pulse
        do_req(1'b0, 8'h10, 16'h0, 2'b11);
        @(negedge clk);
        #1;
        chk(!rsp_done, "R8 done single cycle", rsp_done, 0);

        // sticky monitor results
        chk(dq_early == 0 && dq_stray == 0, "R4 data driver window", dq_early + dq_stray, 0);
        chk(oe_clash == 0, "R3 oe high during write", oe_clash, 0);
        chk(addr_bad == 0, "R10 address stable", addr_bad, 0);

        // reset in the middle of a write
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h40; req_wdata = 16'h7777; req_mask = 2'b11;
        @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        chk({mem_cs_n, mem_cs, mem_we_n, mem_be_n, mem_dq_oe} == 6'b101110, "R1 abort on reset",
            {mem_cs_n, mem_cs, mem_we_n, mem_be_n, mem_dq_oe}, 6'b101110);
        chk(req_ready && rsp_rdata == 16'h0, "R1 ready and rdata after reset", {req_ready, rsp_rdata}, {1'b1, 16'h0});
        @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        do_req(1'b0, 8'h11, 16'h0, 2'b11);
        chk(rsp_rdata == ref_mem[8'h11] && lat == 7, "R2 read after reset", rsp_rdata, ref_mem[8'h11]);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule